// File: doc/BRIEF.md
# Slow-Control Register Bank

This block is the byte-wide configuration store of a multi-channel front-end readout chip. A serial slave front end, outside this block, turns bus transactions into single-cycle write strobes and read strobes, each with an 8-bit address and 8 data bits. Behind that port sit several kinds of storage. There are plain read/write registers for channel masks, analogue front-end settings, a control byte, test delays and timestamp-delay tuning. There is a read-only status byte taken from the chip. There are two saturating diagnostic counters that the readout logic bumps on lost-token and queue-overflow events. There is also a long per-channel trim chain with one byte per channel, test channel included, which is loaded one byte at a time through a single address.

Every stored value drives the channel logic continuously. Mask bits go out as a flat per-channel vector. Each channel's threshold trim and shutdown bit are taken from fixed positions in its chain byte. The counters clear when they are read, so software sees the events since its last poll. A write to the chain address pushes the whole chain along by one byte, and the byte that drops off the end can then be read back. Software can therefore verify a full load by shifting it through a second time.

Top module: `sc_regbank`

## Requirements
- R1: While reset is asserted and after its release, every register, counter and chain byte is zero, so all outputs, `rdata` and `rvalid` are zero.
- R2: Mask registers sit at addresses 0x00–0x0F and are read/write. The mask bit of channel n is bit (n mod 8) of the register at address n/8, and it drives `mask_o[n]`.
- R3: Read/write registers: front-end settings at 0x10–0x1D, control byte at 0x20, test delays at 0x24–0x25 and timestamp delays at 0x26–0x28. Register k of each group drives bits [8k+7:8k] of its output, and a written value reads back unchanged.
- R4: Address 0x21 reads the current `status_i`. Writes to 0x21, 0x22 and 0x23 change nothing.
- R5: The token-lost counter (0x22) and the overflow counter (0x23) each add one per cycle in which their pulse input is high, and they hold at 255.
- R6: Reading a counter returns its value and clears it. If the counter's pulse is high in the same cycle as the read, the counter becomes 1 instead of 0.
- R7: Each write to 0x30 shifts the 129-byte chain by one. The written byte enters channel 128, every byte moves to the next lower channel, and channel 0's byte leaves the chain. After 129 writes, the k-th byte written (counting from 0) sits in channel k.
- R8: For channel c, `trim_o[5c+4:5c]` equals bits 4:0 of its chain byte and `shut_o[c]` equals bit 5.
- R9: A read of 0x30 returns the byte most recently shifted out of channel 0, or 0 if none has been. The read does not shift the chain.
- R10: Reads from any address not listed above return 0, and writes to such addresses change no output.
- R11: `rdata` and `rvalid` are updated one clock after a cycle with `rd_en` high and `wr_en` low. `rvalid` is high for exactly that clock, and `rdata` holds its value otherwise. When `rd_en` and `wr_en` are both high, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rvalid | output | 1 | Read data valid pulse |
| status_i | input | 8 | Chip status byte seen at 0x21 |
| tok_lost_i | input | 1 | Token-lost event pulse |
| fifo_ovf_i | input | 1 | Queue-overflow event pulse |
| mask_o | output | NUM_CH (128) | Per-channel mask bits |
| fe_o | output | 8*NUM_FE (112) | Front-end setting bytes |
| cfg_o | output | 8 | Control byte |
| tdly_o | output | 8*NUM_TDLY (16) | Test-delay bytes |
| tsdly_o | output | 8*NUM_TSDLY (24) | Timestamp-delay bytes |
| trim_o | output | 5*(NUM_CH+1) (645) | Per-channel 5-bit threshold trims |
| shut_o | output | NUM_CH+1 (129) | Per-channel shutdown bits |

## Verification
The bench builds the bank with its default sizes: 128 channels (16 mask bytes and a 129-byte chain), 14 front-end bytes, 2 test-delay bytes and 3 timestamp-delay bytes. With these sizes, a full chain load followed by one extra shift is short enough to run. That exposes the channel-0 and channel-128 ends and the shifted-out byte. The real address map also keeps its group edges, such as 0x1D/0x1E and 0x28/0x29, and its gaps. A 300-cycle burst of overflow pulses drives a counter well past its 255 ceiling, and a read that coincides with a pulse exercises the clear-versus-increment case.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef logic [7:0] byte_t;

    localparam byte_t A_MASK_BASE  = 8'h00;
    localparam byte_t A_FE_BASE    = 8'h10;
    localparam byte_t A_CFG        = 8'h20;
    localparam byte_t A_STATUS     = 8'h21;
    localparam byte_t A_CNT_TOK    = 8'h22;
    localparam byte_t A_CNT_OVF    = 8'h23;
    localparam byte_t A_TDLY_BASE  = 8'h24;
    localparam byte_t A_TSDLY_BASE = 8'h26;
    localparam byte_t A_CHAIN      = 8'h30;

    localparam int TRIM_W = 5;
    localparam int SHUT_BIT = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ARRAY,
        SEL_STATUS,
        SEL_TOK,
        SEL_OVF,
        SEL_CHAIN
    } rd_sel_e;
endpackage

// File: rtl/sc_reg_array.sv
module sc_reg_array
    import sc_pkg::*;
#(
    parameter int N    = 1,
    parameter int BASE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  byte_t          addr,
    input  byte_t          wdata,
    output logic [N*8-1:0] q,
    output logic           hit,
    output byte_t          rd
);
    byte_t regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < N; i++) begin
                if (addr == 8'(BASE + i)) regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        hit = 1'b0;
        rd  = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == 8'(BASE + i)) begin
                hit = 1'b1;
                rd  = regs[i];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign q[g*8 +: 8] = regs[g];
    end
endmodule

// File: rtl/sc_sat_cnt.sv
module sc_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? W'(1) : '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/sc_trim_chain.sv
module sc_trim_chain
    import sc_pkg::*;
#(
    parameter int LEN = 129
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  byte_t            din,
    output logic [LEN*8-1:0] stages,
    output byte_t            dout
);
    byte_t st [LEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LEN; i++) st[i] <= '0;
            dout <= '0;
        end else if (shift) begin
            dout <= st[0];
            for (int i = 0; i < LEN - 1; i++) st[i] <= st[i+1];
            st[LEN-1] <= din;
        end
    end

    for (genvar g = 0; g < LEN; g++) begin : g_flat
        assign stages[g*8 +: 8] = st[g];
    end
endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
    import sc_pkg::*;
#(
    parameter int NUM_CH    = 128,
    parameter int NUM_FE    = 14,
    parameter int NUM_TDLY  = 2,
    parameter int NUM_TSDLY = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [7:0]                 addr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    output logic                       rvalid,
    input  logic [7:0]                 status_i,
    input  logic                       tok_lost_i,
    input  logic                       fifo_ovf_i,
    output logic [NUM_CH-1:0]          mask_o,
    output logic [NUM_FE*8-1:0]        fe_o,
    output logic [7:0]                 cfg_o,
    output logic [NUM_TDLY*8-1:0]      tdly_o,
    output logic [NUM_TSDLY*8-1:0]     tsdly_o,
    output logic [(NUM_CH+1)*5-1:0]    trim_o,
    output logic [NUM_CH:0]            shut_o
);
    localparam int NUM_MASK  = NUM_CH / 8;
    localparam int CHAIN_LEN = NUM_CH + 1;

    logic    rd_fire;
    logic    tok_clr, ovf_clr, chain_shift;
    byte_t   tok_cnt, ovf_cnt, chain_out;
    rd_sel_e rd_sel;
    byte_t   rd_mux, arr_rd;
    logic    arr_hit;
    logic [CHAIN_LEN*8-1:0] chain_flat;

    logic  mask_hit, fe_hit, cfg_hit, tdly_hit, tsdly_hit;
    byte_t mask_rd, fe_rd, cfg_rd, tdly_rd, tsdly_rd;

    assign rd_fire     = rd_en & ~wr_en;
    assign tok_clr     = rd_fire && (addr == A_CNT_TOK);
    assign ovf_clr     = rd_fire && (addr == A_CNT_OVF);
    assign chain_shift = wr_en && (addr == A_CHAIN);

    sc_reg_array #(.N(NUM_MASK), .BASE(int'(A_MASK_BASE))) i_mask (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(addr), .wdata(wdata),
        .q(mask_o), .hit(mask_hit), .rd(mask_rd)
    );
    sc_reg_array #(.N(NUM_FE), .BASE(int'(A_FE_BASE))) i_fe (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(addr), .wdata(wdata),
        .q(fe_o), .hit(fe_hit), .rd(fe_rd)
    );
    sc_reg_array #(.N(1), .BASE(int'(A_CFG))) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(addr), .wdata(wdata),
        .q(cfg_o), .hit(cfg_hit), .rd(cfg_rd)
    );
    sc_reg_array #(.N(NUM_TDLY), .BASE(int'(A_TDLY_BASE))) i_tdly (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(addr), .wdata(wdata),
        .q(tdly_o), .hit(tdly_hit), .rd(tdly_rd)
    );
    sc_reg_array #(.N(NUM_TSDLY), .BASE(int'(A_TSDLY_BASE))) i_tsdly (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(addr), .wdata(wdata),
        .q(tsdly_o), .hit(tsdly_hit), .rd(tsdly_rd)
    );

    sc_sat_cnt #(.W(8)) i_tok_cnt (
        .clk(clk), .rst_n(rst_n), .inc(tok_lost_i), .clr(tok_clr), .cnt(tok_cnt)
    );
    sc_sat_cnt #(.W(8)) i_ovf_cnt (
        .clk(clk), .rst_n(rst_n), .inc(fifo_ovf_i), .clr(ovf_clr), .cnt(ovf_cnt)
    );

    sc_trim_chain #(.LEN(CHAIN_LEN)) i_chain (
        .clk(clk), .rst_n(rst_n), .shift(chain_shift), .din(wdata),
        .stages(chain_flat), .dout(chain_out)
    );

    for (genvar c = 0; c < CHAIN_LEN; c++) begin : g_chan
        assign trim_o[c*TRIM_W +: TRIM_W] = chain_flat[c*8 +: TRIM_W];
        assign shut_o[c]                  = chain_flat[c*8 + SHUT_BIT];
    end

    assign arr_hit = mask_hit | fe_hit | cfg_hit | tdly_hit | tsdly_hit;
    assign arr_rd  = mask_rd | fe_rd | cfg_rd | tdly_rd | tsdly_rd;

    always_comb begin
        if (arr_hit) begin
            rd_sel = SEL_ARRAY;
        end else begin
            unique case (addr)
                A_STATUS:  rd_sel = SEL_STATUS;
                A_CNT_TOK: rd_sel = SEL_TOK;
                A_CNT_OVF: rd_sel = SEL_OVF;
                A_CHAIN:   rd_sel = SEL_CHAIN;
                default:   rd_sel = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_ARRAY:  rd_mux = arr_rd;
            SEL_STATUS: rd_mux = status_i;
            SEL_TOK:    rd_mux = tok_cnt;
            SEL_OVF:    rd_mux = ovf_cnt;
            SEL_CHAIN:  rd_mux = chain_out;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_fire;
            if (rd_fire) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/sc_regbank_chk.sv
module sc_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       rvalid,
    input logic       tok_lost_i,
    input logic [7:0] tok_cnt,
    input logic [7:0] mask_lo,
    input logic [7:0] cfg_o,
    input logic       shut_top,
    input logic [4:0] trim_top
);
    logic rd_ok, tok_rd;
    assign rd_ok  = rd_en && !wr_en;
    assign tok_rd = rd_ok && (addr == 8'h22);

    p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> rvalid);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> (!rvalid && $stable(rdata)));

    p_tok_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_cnt == 8'hFF && !tok_rd) |=> tok_cnt == 8'hFF);

    p_tok_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_rd && tok_lost_i && tok_cnt != 8'hFF) |=> tok_cnt == $past(tok_cnt) + 8'd1);

    p_tok_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_rd && !tok_lost_i) |=> tok_cnt == 8'd0);

    p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h00) |=> mask_lo == $past(wdata));

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 8'h20) |=> $stable(cfg_o));

    p_chain_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h30) |=> (shut_top == $past(wdata[5]) && trim_top == $past(wdata[4:0])));
endmodule

bind sc_regbank sc_regbank_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .tok_lost_i(tok_lost_i),
    .tok_cnt(tok_cnt), .mask_lo(mask_o[7:0]), .cfg_o(cfg_o),
    .shut_top(shut_o[CHAIN_LEN-1]), .trim_top(trim_o[CHAIN_LEN*5-1 -: 5])
);

// File: tb/test_sc_regbank.sv
module test_sc_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 128;
    localparam int NLEN = NCH + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0, status_i = '0;
    logic tok_lost_i = 1'b0, fifo_ovf_i = 1'b0;
    logic [7:0] rdata, cfg_o;
    logic rvalid;
    logic [NCH-1:0] mask_o;
    logic [111:0] fe_o;
    logic [15:0] tdly_o;
    logic [23:0] tsdly_o;
    logic [NLEN*5-1:0] trim_o;
    logic [NLEN-1:0] shut_o;

    int n_run = 0, n_fail = 0;
    bit done = 0, cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_regbank i_sc_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .status_i(status_i),
        .tok_lost_i(tok_lost_i), .fifo_ovf_i(fifo_ovf_i), .mask_o(mask_o),
        .fe_o(fe_o), .cfg_o(cfg_o), .tdly_o(tdly_o), .tsdly_o(tsdly_o),
        .trim_o(trim_o), .shut_o(shut_o)
    );

    task automatic chk(string req, logic [1023:0] act, logic [1023:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mreg [256];
    int tok_m, ovf_m;
    logic [7:0] chain_q [$];
    logic [7:0] last_m, rdata_m;
    bit rvalid_m, m_rd;
    int m_a;

    function automatic bit writable(int a);
        return (a < 16) || (a >= 16 && a < 30) || a == 32 || (a >= 36 && a <= 40);
    endfunction

    function automatic logic [7:0] mdl_read(int a);
        if (writable(a)) return mreg[a];
        if (a == 33) return status_i;
        if (a == 34) return 8'(tok_m);
        if (a == 35) return 8'(ovf_m);
        if (a == 48) return last_m;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mreg[i]) mreg[i] = '0;
            tok_m = 0; ovf_m = 0; last_m = '0; rdata_m = '0; rvalid_m = 0;
            chain_q.delete();
            repeat (NLEN) chain_q.push_back(8'h00);
        end else begin
            m_rd = rd_en && !wr_en;
            m_a = int'(addr);
            rvalid_m = m_rd;
            if (m_rd) rdata_m = mdl_read(m_a);
            if (m_rd && m_a == 34) tok_m = tok_lost_i ? 1 : 0;
            else if (tok_lost_i && tok_m < 255) tok_m++;
            if (m_rd && m_a == 35) ovf_m = fifo_ovf_i ? 1 : 0;
            else if (fifo_ovf_i && ovf_m < 255) ovf_m++;
            if (wr_en) begin
                if (m_a == 48) begin
                    last_m = chain_q.pop_front();
                    chain_q.push_back(wdata);
                end else if (writable(m_a)) begin
                    mreg[m_a] = wdata;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            logic [NCH-1:0] em;
            logic [111:0] ef;
            logic [15:0] et;
            logic [23:0] es;
            logic [NLEN*5-1:0] etr;
            logic [NLEN-1:0] esh;
            for (int n = 0; n < NCH; n++) em[n] = mreg[n/8][n%8];
            for (int k = 0; k < 14; k++) ef[k*8 +: 8] = mreg[16+k];
            for (int k = 0; k < 2; k++) et[k*8 +: 8] = mreg[36+k];
            for (int k = 0; k < 3; k++) es[k*8 +: 8] = mreg[38+k];
            for (int c = 0; c < NLEN; c++) begin
                etr[c*5 +: 5] = chain_q[c][4:0];
                esh[c] = chain_q[c][5];
            end
            chk("R2/R10 mask_o", mask_o, em);
            chk("R3/R10 fe_o", fe_o, ef);
            chk("R3 cfg_o", cfg_o, mreg[32]);
            chk("R3 tdly_o", tdly_o, et);
            chk("R3 tsdly_o", tsdly_o, es);
            chk("R7/R8 trim_o", trim_o, etr);
            chk("R7/R8 shut_o", shut_o, esh);
            chk("R11 rvalid", rvalid, rvalid_m);
            chk("R11 rdata", rdata, rdata_m);
        end
    end

    // ---------------- stimulus tasks (called at a negedge) ----------------
    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            done = 1;
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mask_o", mask_o, '0);
        chk("R1 cfg_o", cfg_o, '0);
        chk("R1 trim_o", trim_o, '0);
        chk("R1 shut_o", shut_o, '0);
        chk("R1 rdata/rvalid", {rdata, rvalid}, '0);
        rst_n = 1'b1;
        status_i = 8'hA5;
        @(negedge clk);
        cmp_on = 1;

        // R2: masks
        for (int i = 0; i < 16; i++) wr(8'(i), 8'(i*37 + 5));
        for (int i = 0; i < 16; i++) rd_chk(8'(i), 8'(i*37 + 5), "R2 mask readback");
        // channel 77 -> reg 9 bit 5: (9*37+5)=338 -> 0x52 -> bit5 = 0; channel 76 -> bit4 = 1
        chk("R2 mask ch77", mask_o[77], 1'b0);
        chk("R2 mask ch76", mask_o[76], 1'b1);

        // R3: other read/write groups
        for (int i = 0; i < 14; i++) wr(8'(16 + i), 8'(8'hC0 + i));
        wr(8'h20, 8'h3C);
        wr(8'h24, 8'h11); wr(8'h25, 8'h22);
        wr(8'h26, 8'h33); wr(8'h27, 8'h44); wr(8'h28, 8'h55);
        rd_chk(8'h1D, 8'hCD, "R3 fe last");
        rd_chk(8'h20, 8'h3C, "R3 cfg");
        rd_chk(8'h28, 8'h55, "R3 tsdly last");
        chk("R3 tdly_o", tdly_o, 16'h2211);

        // R4 / R10: read-only and unused addresses
        wr(8'h21, 8'hFF); wr(8'h22, 8'hFF); wr(8'h23, 8'hFF);
        wr(8'h1E, 8'h77); wr(8'h29, 8'h77); wr(8'h40, 8'h77);
        rd_chk(8'h21, 8'hA5, "R4 status");
        rd_chk(8'h22, 8'h00, "R4 tok write ignored");
        rd_chk(8'h23, 8'h00, "R4 ovf write ignored");
        rd_chk(8'h1E, 8'h00, "R10 unused 0x1E");
        rd_chk(8'h29, 8'h00, "R10 unused 0x29");
        rd_chk(8'h40, 8'h00, "R10 unused 0x40");

        // R5 / R6: counters
        tok_lost_i = 1'b1;
        repeat (10) @(negedge clk);
        tok_lost_i = 1'b0;
        rd_chk(8'h22, 8'd10, "R6 tok value");
        rd_chk(8'h22, 8'd0, "R6 tok cleared");
        fifo_ovf_i = 1'b1;
        repeat (300) @(negedge clk);
        fifo_ovf_i = 1'b0;
        rd_chk(8'h23, 8'd255, "R5 ovf saturated");
        fifo_ovf_i = 1'b1;
        rd_chk(8'h23, 8'd0, "R6 read with pulse");
        fifo_ovf_i = 1'b0;
        rd_chk(8'h23, 8'd1, "R6 pulse kept over clear");

        // R7 / R8 / R9: trim chain
        for (int k = 0; k < NLEN; k++) wr(8'h30, 8'(k*7 + 3));
        chk("R8 ch0 trim", trim_o[4:0], 5'd3);
        chk("R8 ch128 shut", shut_o[128], 1'(((128*7 + 3) >> 5) & 1));
        chk("R7 ch64 trim", trim_o[64*5 +: 5], 5'((64*7 + 3) & 31));
        rd_chk(8'h30, 8'h00, "R9 nothing shifted out yet");
        wr(8'h30, 8'hFF);
        rd_chk(8'h30, 8'd3, "R9 shifted-out byte");
        rd_chk(8'h30, 8'd3, "R9 read does not shift");
        chk("R7 ch0 after shift", trim_o[4:0], 5'd10);
        chk("R7 ch128 new byte", {shut_o[128], trim_o[128*5 +: 5]}, 6'h3F);

        // R11: simultaneous read and write
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h20; wdata = 8'h9A;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11 read dropped", rvalid, 1'b0);
        chk("R11 write kept", cfg_o, 8'h9A);

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule